// File: doc/BRIEF.md
# Nibble-Configurable Handshake Port

This block is an 8-bit bidirectional port split into two 4-bit halves. A mode register sets each half to input, output, or high-address output. In address mode the lower half carries address bits 11..8 and the upper half carries bits 15..12. The port can also run a two-wire handshake: an active-low data-available strobe and a ready line. The handshake is allowed only when both halves point the same way. The direction of the upper half then decides which of the two handshake pins is driven and which is sensed.

A CPU writes either the mode register or the data register through one write port, and reads the port through a combinational read bus. A boot strap input picks the reset configuration. With the strap low, the port resets as a plain input port. With the strap high, which stands for booting without on-chip program memory, both halves come out of reset driving address bits.

The handshake sequencer is a state machine with these states:
- `HS_OFF`: handshake disabled.
- Output side: `OUT_IDLE`, `OUT_LOAD`, `OUT_STROBE`, `OUT_RELEASE`.
- Input side: `IN_EMPTY`, `IN_FULL`.

Its transitions are:
- Every mode write leads to `OUT_IDLE`, to `IN_EMPTY`, or to `HS_OFF`. A write with an accepted enable goes to `OUT_IDLE` when the upper half is output and to `IN_EMPTY` when it is input. Any other mode write goes to `HS_OFF`.
- `OUT_IDLE` goes to `OUT_LOAD` on a data write.
- `OUT_LOAD` goes to `OUT_STROBE` after one cycle.
- `OUT_STROBE` goes to `OUT_RELEASE` when ready is high.
- `OUT_RELEASE` goes to `OUT_IDLE` when ready is low.
- `IN_EMPTY` goes to `IN_FULL` on a falling data-available edge.
- `IN_FULL` goes to `IN_EMPTY` on a CPU read.

Top module: `hs_port`

## Requirements
- R1: With the boot strap low, reset leaves both halves as inputs and drives no pads (`pad_oe` = 00). Neither handshake pin is driven, and `hs_err` is 0.
- R2: With the boot strap high, reset leaves both halves in address mode. All eight pads are driven and `pad_out` follows `addr_hi`.
- R3: A write with `wr_sel`=0 loads the mode register, and each half is set independently.
  - Bits [1:0] select the lower half and bits [3:2] select the upper half.
  - The codes are 00 input, 01 output and 10 address. Code 11 acts as input.
  - An output half drives the data-register nibble and reads that nibble back on `rd_data`.
  - An input half drives nothing and, with no handshake active, reads its pads.
- R4: An address-mode half drives its nibble of `addr_hi`. The lower half carries bits 3..0 and the upper half carries bits 7..4.
- R5: Bit 4 of a mode write requests the handshake. The request is accepted only when both halves are input or both are output. Otherwise the request is ignored: no handshake pin is driven and `hs_err` goes to 1. Any later mode write without such a conflict clears `hs_err`.
- R6: In output handshake, a data write shows on the pads one cycle after it is taken. `dav_n_out` goes low one cycle after that.
- R7: `dav_n_out` stays low while `rdy_in` is low. It returns high in the cycle after `rdy_in` is seen high.
- R8: After a strobe, data writes are ignored until `rdy_in` has been seen low. A write taken after that is driven normally.
- R9: In input handshake, `rdy_out` is high while the latch is empty. A falling `dav_n_in` latches the pads and drops `rdy_out`, and `rd_data` then shows the latched byte even if the pads change.
- R10: While the latch is full, further falling strobes are ignored. A read pulse on `rd_en` empties the latch and raises `rdy_out` again.
- R11: The data-available pin is driven (`dav_oe`=1) only in output handshake, and the ready pin is driven (`rdy_oe`=1) only in input handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| boot_no_rom | input | 1 | Reset strap: 1 selects address mode on both halves |
| wr_en | input | 1 | CPU write strobe |
| wr_sel | input | 1 | 0 selects the mode register, 1 selects the data register |
| wr_data | input | 8 | CPU write data |
| rd_en | input | 1 | CPU read strobe; empties the input handshake latch |
| rd_data | output | 8 | CPU read data |
| addr_hi | input | 8 | High address byte for address mode |
| pad_in | input | 8 | Pad input values |
| pad_out | output | 8 | Pad output values |
| pad_oe | output | 8 | Pad output enables, one per bit |
| dav_n_in | input | 1 | Sensed data-available strobe, active low |
| dav_n_out | output | 1 | Driven data-available strobe, active low |
| dav_oe | output | 1 | Output enable of the data-available pin |
| rdy_in | input | 1 | Sensed ready line |
| rdy_out | output | 1 | Driven ready line |
| rdy_oe | output | 1 | Output enable of the ready pin |
| hs_err | output | 1 | Set when a handshake request was rejected |

## Verification
Mixed mode settings are used to show the two halves behave independently:
- Input below output, and address next to output in both orders.
- Swapping address mode between halves tells a lower/upper mix-up apart from a correct mapping.

Handshake requests are made with halves that differ and with both halves in address mode; a wrong direction-match rule lets one of these through.

The output handshake is run with a slow acknowledge and with a write attempted while ready is still high, which separates a released strobe from a stuck one and a blocked write from a lost one. The input handshake is run with pads changed after the latch and with a second strobe while full, which shows latch-versus-pass-through and full-state blocking.

// File: rtl/hsp_pkg.sv
`timescale 1ns/1ps
package hsp_pkg;
    localparam int MODE_LO_LSB = 0;
    localparam int MODE_HI_LSB = 2;
    localparam int MODE_EN_BIT = 4;
    localparam int MODE_W      = 5;

    typedef enum logic [1:0] {
        NIB_IN   = 2'b00,
        NIB_OUT  = 2'b01,
        NIB_ADDR = 2'b10,
        NIB_RSVD = 2'b11
    } nib_mode_t;

    typedef enum logic [2:0] {
        HS_OFF,
        OUT_IDLE,
        OUT_LOAD,
        OUT_STROBE,
        OUT_RELEASE,
        IN_EMPTY,
        IN_FULL
    } hs_state_t;

    function automatic nib_mode_t decode_nib(input logic [1:0] code);
        nib_mode_t m;
        unique case (code)
            2'b01:   m = NIB_OUT;
            2'b10:   m = NIB_ADDR;
            default: m = NIB_IN;
        endcase
        return m;
    endfunction
endpackage

// File: rtl/hsp_mode_reg.sv
`timescale 1ns/1ps
module hsp_mode_reg
    import hsp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              boot_no_rom,
    input  logic              mode_wr,
    input  logic [MODE_W-1:0] cfg,
    output nib_mode_t         lo_mode,
    output nib_mode_t         hi_mode,
    output logic              hs_en,
    output logic              hs_err,
    output logic              accept,
    output logic              req_out
);
    nib_mode_t req_lo;
    nib_mode_t req_hi;
    logic      dir_match;

    assign req_lo    = decode_nib(cfg[MODE_LO_LSB +: 2]);
    assign req_hi    = decode_nib(cfg[MODE_HI_LSB +: 2]);
    assign dir_match = (req_lo == req_hi) && (req_hi != NIB_ADDR);
    assign accept    = cfg[MODE_EN_BIT] && dir_match;
    assign req_out   = (req_hi == NIB_OUT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_mode <= boot_no_rom ? NIB_ADDR : NIB_IN;
            hi_mode <= boot_no_rom ? NIB_ADDR : NIB_IN;
            hs_en   <= 1'b0;
            hs_err  <= 1'b0;
        end else if (mode_wr) begin
            lo_mode <= req_lo;
            hi_mode <= req_hi;
            hs_en   <= accept;
            hs_err  <= cfg[MODE_EN_BIT] && !dir_match;
        end
    end

    // R5: a rejected request leaves handshake off and raises the error flag
    assert_reject_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_wr && cfg[MODE_EN_BIT] && !dir_match) |=> (hs_err && !hs_en));

    // R5: an enabled handshake always has matching half directions
    assert_en_match_R5: assert property (@(posedge clk) disable iff (!rst_n)
        hs_en |-> (lo_mode == hi_mode && lo_mode != NIB_ADDR));
endmodule

// File: rtl/hsp_hs_fsm.sv
`timescale 1ns/1ps
module hsp_hs_fsm
    import hsp_pkg::*;
#(
    parameter int PORT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_wr,
    input  logic              accept,
    input  logic              req_out,
    input  logic              data_wr,
    input  logic [PORT_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [PORT_W-1:0] pad_in,
    input  logic              dav_n_in,
    input  logic              rdy_in,
    output logic [PORT_W-1:0] data_q,
    output logic              hs_active,
    output logic              dav_n_out,
    output logic              dav_oe,
    output logic              rdy_out,
    output logic              rdy_oe
);
    hs_state_t state;
    hs_state_t state_nxt;
    logic      dav_prev;
    logic      dav_fall;

    assign dav_fall = dav_prev && !dav_n_in;

    always_comb begin
        state_nxt = state;
        if (mode_wr) begin
            state_nxt = accept ? (req_out ? OUT_IDLE : IN_EMPTY) : HS_OFF;
        end else begin
            unique case (state)
                HS_OFF:      state_nxt = HS_OFF;
                OUT_IDLE:    if (data_wr) state_nxt = OUT_LOAD;
                OUT_LOAD:    state_nxt = OUT_STROBE;
                OUT_STROBE:  if (rdy_in) state_nxt = OUT_RELEASE;
                OUT_RELEASE: if (!rdy_in) state_nxt = OUT_IDLE;
                IN_EMPTY:    if (dav_fall) state_nxt = IN_FULL;
                IN_FULL:     if (rd_en) state_nxt = IN_EMPTY;
                default:     state_nxt = HS_OFF;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= HS_OFF;
            dav_prev <= 1'b1;
            data_q   <= '0;
        end else begin
            state    <= state_nxt;
            dav_prev <= dav_n_in;
            if (!mode_wr) begin
                if (data_wr && (state == HS_OFF || state == OUT_IDLE))
                    data_q <= wr_data;
                else if (state == IN_EMPTY && dav_fall)
                    data_q <= pad_in;
            end
        end
    end

    always_comb begin
        dav_n_out = 1'b1;
        dav_oe    = 1'b0;
        rdy_out   = 1'b0;
        rdy_oe    = 1'b0;
        hs_active = 1'b1;
        unique case (state)
            HS_OFF:      hs_active = 1'b0;
            OUT_IDLE:    dav_oe = 1'b1;
            OUT_LOAD:    dav_oe = 1'b1;
            OUT_STROBE:  begin dav_oe = 1'b1; dav_n_out = 1'b0; end
            OUT_RELEASE: dav_oe = 1'b1;
            IN_EMPTY:    begin rdy_oe = 1'b1; rdy_out = 1'b1; end
            IN_FULL:     rdy_oe = 1'b1;
            default:     hs_active = 1'b0;
        endcase
    end

    // R6: strobe follows the load cycle
    assert_strobe_after_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == OUT_LOAD && !mode_wr) |=> (!dav_n_out && dav_oe));

    // R7: ready high releases the strobe
    assert_dav_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (dav_oe && !dav_n_out && rdy_in && !mode_wr) |=> dav_n_out);

    // R8: writes during a transfer leave the data register untouched
    assert_write_blocked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && !mode_wr && (state == OUT_LOAD || state == OUT_STROBE || state == OUT_RELEASE))
        |=> $stable(data_q));

    // R9: a falling strobe when empty captures the pads and drops ready
    assert_in_latch_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy_oe && rdy_out && dav_fall && !mode_wr) |=> (!rdy_out && data_q == $past(pad_in)));

    // R10: a full latch holds until read
    assert_full_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy_oe && !rdy_out && !rd_en && !mode_wr) |=> ($stable(data_q) && !rdy_out));

    // R11: at most one handshake pin is driven
    assert_pin_dir_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({dav_oe, rdy_oe}));
endmodule

// File: rtl/hsp_nibble_mux.sv
`timescale 1ns/1ps
module hsp_nibble_mux
    import hsp_pkg::*;
#(
    parameter int NIB_W = 4
) (
    input  nib_mode_t           lo_mode,
    input  nib_mode_t           hi_mode,
    input  logic                hs_active,
    input  logic [2*NIB_W-1:0]  data_q,
    input  logic [2*NIB_W-1:0]  addr_hi,
    input  logic [2*NIB_W-1:0]  pad_in,
    output logic [2*NIB_W-1:0]  pad_out,
    output logic [2*NIB_W-1:0]  pad_oe,
    output logic [2*NIB_W-1:0]  rd_data
);
    localparam int NIBS = 2;

    for (genvar n = 0; n < NIBS; n++) begin : g_nib
        nib_mode_t  m;
        logic [NIB_W-1:0] po;
        logic [NIB_W-1:0] rd;
        logic             drive;

        assign m     = (n == 0) ? lo_mode : hi_mode;
        assign drive = (m == NIB_OUT) || (m == NIB_ADDR);
        assign po    = (m == NIB_OUT)  ? data_q[n*NIB_W +: NIB_W] :
                       (m == NIB_ADDR) ? addr_hi[n*NIB_W +: NIB_W] : '0;
        assign rd    = ((m == NIB_OUT) || (m == NIB_IN && hs_active))
                       ? data_q[n*NIB_W +: NIB_W] : pad_in[n*NIB_W +: NIB_W];

        assign pad_out[n*NIB_W +: NIB_W] = po;
        assign pad_oe [n*NIB_W +: NIB_W] = {NIB_W{drive}};
        assign rd_data[n*NIB_W +: NIB_W] = rd;
    end
endmodule

// File: rtl/hs_port.sv
`timescale 1ns/1ps
module hs_port
    import hsp_pkg::*;
#(
    parameter int NIB_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               boot_no_rom,
    input  logic               wr_en,
    input  logic               wr_sel,
    input  logic [2*NIB_W-1:0] wr_data,
    input  logic               rd_en,
    output logic [2*NIB_W-1:0] rd_data,
    input  logic [2*NIB_W-1:0] addr_hi,
    input  logic [2*NIB_W-1:0] pad_in,
    output logic [2*NIB_W-1:0] pad_out,
    output logic [2*NIB_W-1:0] pad_oe,
    input  logic               dav_n_in,
    output logic               dav_n_out,
    output logic               dav_oe,
    input  logic               rdy_in,
    output logic               rdy_out,
    output logic               rdy_oe,
    output logic               hs_err
);
    localparam int PORT_W = 2 * NIB_W;

    logic        mode_wr;
    logic        data_wr;
    nib_mode_t   lo_mode;
    nib_mode_t   hi_mode;
    logic        hs_en;
    logic        accept;
    logic        req_out;
    logic        hs_active;
    logic [PORT_W-1:0] data_q;

    assign mode_wr = wr_en && !wr_sel;
    assign data_wr = wr_en && wr_sel;

    hsp_mode_reg u_mode (
        .clk        (clk),
        .rst_n      (rst_n),
        .boot_no_rom(boot_no_rom),
        .mode_wr    (mode_wr),
        .cfg        (wr_data[MODE_W-1:0]),
        .lo_mode    (lo_mode),
        .hi_mode    (hi_mode),
        .hs_en      (hs_en),
        .hs_err     (hs_err),
        .accept     (accept),
        .req_out    (req_out)
    );

    hsp_hs_fsm #(.PORT_W(PORT_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_wr   (mode_wr),
        .accept    (accept),
        .req_out   (req_out),
        .data_wr   (data_wr),
        .wr_data   (wr_data),
        .rd_en     (rd_en),
        .pad_in    (pad_in),
        .dav_n_in  (dav_n_in),
        .rdy_in    (rdy_in),
        .data_q    (data_q),
        .hs_active (hs_active),
        .dav_n_out (dav_n_out),
        .dav_oe    (dav_oe),
        .rdy_out   (rdy_out),
        .rdy_oe    (rdy_oe)
    );

    hsp_nibble_mux #(.NIB_W(NIB_W)) u_mux (
        .lo_mode  (lo_mode),
        .hi_mode  (hi_mode),
        .hs_active(hs_active),
        .data_q   (data_q),
        .addr_hi  (addr_hi),
        .pad_in   (pad_in),
        .pad_out  (pad_out),
        .pad_oe   (pad_oe),
        .rd_data  (rd_data)
    );

    // R11: sequencer activity agrees with the accepted enable
    assert_active_en_R11: assert property (@(posedge clk) disable iff (!rst_n)
        hs_active |-> hs_en);

    // R4: address-mode halves drive their address nibble
    assert_addr_lo_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_mode == NIB_ADDR) |-> (pad_out[NIB_W-1:0] == addr_hi[NIB_W-1:0]));
endmodule

// File: tb/test_hs_port.sv
`timescale 1ns/1ps
module test_hs_port;
    localparam int NW = 4;
    localparam int PW = 2 * NW;

    localparam int K_PAD_OUT = 0, K_PAD_OE = 1, K_RD = 2, K_DAV_N = 3,
                   K_DAV_OE = 4, K_RDY = 5, K_RDY_OE = 6, K_ERR = 7;

    typedef struct {
        int          kind;
        logic [7:0]  exp;
        string       req;
        string       what;
    } sb_item_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          boot_no_rom = 1'b0;
    logic          wr_en = 1'b0;
    logic          wr_sel = 1'b0;
    logic [PW-1:0] wr_data = '0;
    logic          rd_en = 1'b0;
    logic [PW-1:0] rd_data;
    logic [PW-1:0] addr_hi = '0;
    logic [PW-1:0] pad_in = '0;
    logic [PW-1:0] pad_out;
    logic [PW-1:0] pad_oe;
    logic          dav_n_in = 1'b1;
    logic          dav_n_out;
    logic          dav_oe;
    logic          rdy_in = 1'b0;
    logic          rdy_out;
    logic          rdy_oe;
    logic          hs_err;

    int       checks = 0;
    int       failures = 0;
    bit       done = 1'b0;
    sb_item_t sb[$];
    sb_item_t it;

    always #2.5 clk = ~clk;

    hs_port #(.NIB_W(NW)) i_hs_port (
        .clk(clk), .rst_n(rst_n), .boot_no_rom(boot_no_rom),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .addr_hi(addr_hi),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
        .dav_n_in(dav_n_in), .dav_n_out(dav_n_out), .dav_oe(dav_oe),
        .rdy_in(rdy_in), .rdy_out(rdy_out), .rdy_oe(rdy_oe),
        .hs_err(hs_err)
    );

    function automatic logic [7:0] probe(input int kind);
        case (kind)
            K_PAD_OUT: return pad_out;
            K_PAD_OE:  return pad_oe;
            K_RD:      return rd_data;
            K_DAV_N:   return {7'd0, dav_n_out};
            K_DAV_OE:  return {7'd0, dav_oe};
            K_RDY:     return {7'd0, rdy_out};
            K_RDY_OE:  return {7'd0, rdy_oe};
            default:   return {7'd0, hs_err};
        endcase
    endfunction

    // monitor: compares queued expectations mid-cycle
    always @(negedge clk) begin
        while (sb.size() > 0) begin
            logic [7:0] got;
            it  = sb.pop_front();
            got = probe(it.kind);
            checks++;
            if (got !== it.exp) begin
                failures++;
                $display("FAIL %s %s: got=%h expected=%h", it.req, it.what, got, it.exp);
            end
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic expect_sig(input int kind, input logic [7:0] v, input string req, input string what);
        sb.push_back('{kind, v, req, what});
    endtask

    task automatic write_reg(input logic sel, input logic [7:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        step();
        wr_en = 1'b0;
    endtask

    task automatic do_reset(input logic boot);
        rst_n = 1'b0; boot_no_rom = boot;
        step(); step();
        rst_n = 1'b1;
        step();
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        #(5.0 * 20000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: got=timeout expected=completion");
            finish_run();
        end
    end

    initial begin
        pad_in = 8'hA5;
        do_reset(1'b0);
        // R1: plain reset state
        expect_sig(K_PAD_OE, 8'h00, "R1", "pad_oe after reset");
        expect_sig(K_DAV_OE, 8'h00, "R1", "dav_oe after reset");
        expect_sig(K_RDY_OE, 8'h00, "R1", "rdy_oe after reset");
        expect_sig(K_ERR,    8'h00, "R1", "hs_err after reset");
        expect_sig(K_RD,     8'hA5, "R3", "input halves read pads");
        step();

        // R3: lower output, upper input
        write_reg(1'b0, 8'h01);
        write_reg(1'b1, 8'h3C);
        expect_sig(K_PAD_OE,  8'h0F, "R3", "lower half driven only");
        expect_sig(K_PAD_OUT, 8'h0C, "R3", "lower data nibble");
        expect_sig(K_RD,      8'hAC, "R3", "mixed read");
        step();

        // R4: address mode in each half
        addr_hi = 8'h9E;
        write_reg(1'b0, 8'h06);
        expect_sig(K_PAD_OE,  8'hFF, "R4", "all pads driven");
        expect_sig(K_PAD_OUT, 8'h3E, "R4", "lower addr, upper data");
        step();
        write_reg(1'b0, 8'h09);
        expect_sig(K_PAD_OUT, 8'h9C, "R4", "upper addr, lower data");
        step();

        // R5: rejected handshake requests
        write_reg(1'b0, 8'h11);
        expect_sig(K_ERR,    8'h01, "R5", "mismatch flagged");
        expect_sig(K_DAV_OE, 8'h00, "R5", "no dav drive on reject");
        expect_sig(K_RDY_OE, 8'h00, "R5", "no rdy drive on reject");
        step();
        write_reg(1'b0, 8'h1A);
        expect_sig(K_ERR, 8'h01, "R5", "both-address request rejected");
        step();
        write_reg(1'b0, 8'h00);
        expect_sig(K_ERR, 8'h00, "R5", "flag cleared");
        step();

        // R11/R6: output handshake
        write_reg(1'b0, 8'h15);
        expect_sig(K_ERR,    8'h00, "R5", "matching request accepted");
        expect_sig(K_DAV_OE, 8'h01, "R11", "dav driven in output handshake");
        expect_sig(K_RDY_OE, 8'h00, "R11", "rdy sensed in output handshake");
        expect_sig(K_DAV_N,  8'h01, "R6", "strobe idle high");
        step();
        write_reg(1'b1, 8'h5A);
        expect_sig(K_PAD_OUT, 8'h5A, "R6", "data on pads");
        expect_sig(K_DAV_N,   8'h01, "R6", "strobe not yet low");
        step();
        expect_sig(K_DAV_N, 8'h00, "R6", "strobe low");
        step();
        expect_sig(K_DAV_N, 8'h00, "R7", "strobe held while ready low");
        rdy_in = 1'b1;
        step();
        expect_sig(K_DAV_N, 8'h01, "R7", "strobe released");
        write_reg(1'b1, 8'hC3);
        expect_sig(K_PAD_OUT, 8'h5A, "R8", "write blocked while ready high");
        rdy_in = 1'b0;
        step();
        write_reg(1'b1, 8'h77);
        expect_sig(K_PAD_OUT, 8'h77, "R8", "write taken after ready low");
        step();

        // R11/R9: input handshake
        write_reg(1'b0, 8'h10);
        expect_sig(K_RDY_OE, 8'h01, "R11", "rdy driven in input handshake");
        expect_sig(K_DAV_OE, 8'h00, "R11", "dav sensed in input handshake");
        expect_sig(K_RDY,    8'h01, "R9", "ready high when empty");
        expect_sig(K_PAD_OE, 8'h00, "R9", "pads released");
        pad_in = 8'h81; dav_n_in = 1'b0;
        step();
        expect_sig(K_RDY, 8'h00, "R9", "ready dropped after strobe");
        expect_sig(K_RD,  8'h81, "R9", "latched byte");
        pad_in = 8'h22; dav_n_in = 1'b1;
        step();
        expect_sig(K_RD, 8'h81, "R9", "latch holds over pad change");
        pad_in = 8'h33; dav_n_in = 1'b0;
        step();
        expect_sig(K_RD,  8'h81, "R10", "strobe while full ignored");
        expect_sig(K_RDY, 8'h00, "R10", "ready stays low while full");
        dav_n_in = 1'b1; rd_en = 1'b1;
        step();
        rd_en = 1'b0;
        expect_sig(K_RDY, 8'h01, "R10", "read empties latch");
        step();
        pad_in = 8'h44; dav_n_in = 1'b0;
        step();
        expect_sig(K_RD, 8'h44, "R9", "second byte latched");
        dav_n_in = 1'b1;
        step();

        // R2: boot without program memory
        addr_hi = 8'h9E;
        do_reset(1'b1);
        expect_sig(K_PAD_OE,  8'hFF, "R2", "address drive after boot reset");
        expect_sig(K_PAD_OUT, 8'h9E, "R2", "address byte on pads");
        expect_sig(K_DAV_OE,  8'h00, "R2", "no handshake after boot reset");
        step();
        addr_hi = 8'h47;
        expect_sig(K_PAD_OUT, 8'h47, "R2", "pads follow address");
        step();
        step();

        done = 1'b1;
        finish_run();
    end
endmodule